// File: doc/BRIEF.md
# Banked Static-RAM Access Controller

This controller sits between an internal word-addressed request port and an external asynchronous static-RAM bus with a 16-bit address, a 16-bit data path and four active-low chip selects. The 64K-word space is split into as many as four banks. The split is set by four 8-bit boundary registers, which are compared against the upper byte of the word address. For every word the controller asserts the chip select of the matching bank. It shapes the write or read strobe around a setup cycle, a strobe window and a release cycle. The strobe window can be stretched by a programmable count of 0 to 7 wait states.

A single request can move one word or a run of consecutive words. In a run, the address steps up by one after each word. For writes, each new data word is taken from the request port. For reads, each captured word is returned with a one-cycle completion pulse. A small configuration port writes the boundary and wait-state registers at any time. A new value takes effect from the next word whose setup starts after the write.

Top module: `sram_part_ctrl`

## Requirements
- R1: After reset and whenever `busy` is low, all four `mem_cs_n` bits, `mem_we_n` and `mem_oe_n` are high. Reset boundaries are 0x00, 0x40, 0x80, 0xC0 and the reset wait-state count is 0.
- R2: While `busy` is high, exactly one `mem_cs_n` bit is low. The two strobes are never low in the same cycle.
- R3: The bank for a word is the highest n (0..3) whose boundary is at or below bits [15:8] of the address, else bank 0. Bank n drives `mem_cs_n[n]` low, so bank 0 is bit 0.
- R4: A write drives address, data (`mem_dq_oe` high) and chip select for one cycle with `mem_we_n` high. It then holds `mem_we_n` low for 1 + wait-state cycles, then keeps address and chip select for one cycle with `mem_we_n` high.
- R5: A read follows the same setup, strobe and release pattern on `mem_oe_n`. `mem_dq_i` is sampled at the clock edge that ends the last strobe cycle, and that word appears on `rd_data` while `done` is high.
- R6: `done` is high for exactly one cycle per word: the release cycle of reads and of writes.
- R7: A configuration write with `cfg_sel` 0..3 loads boundary n from `cfg_wdata`. With `cfg_sel` = 4 it loads the wait-state count from `cfg_wdata[2:0]`. Values 5..7 change nothing.
- R8: A request moves `req_len` words (0 counts as 1) from `req_addr` upward, wrapping from 0xFFFF to 0x0000. Chip select is decoded again for every word.
- R9: In a multi-word write, the data for the next word is `req_wdata` sampled at the end of the cycle in which `done` is high for the previous word.
- R10: A request is taken only when `req_valid` is high while `busy` is low. `req_valid` during an access has no effect.
- R11: Boundaries and wait states are latched per word at acceptance or address step. A configuration write in the same cycle as the acceptance does not affect that word, but does affect later words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0..3 boundary, 4 wait states |
| cfg_wdata | input | 8 | Configuration write value |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Start word address |
| req_len | input | 16 | Number of words (0 treated as 1) |
| req_wdata | input | 16 | Write data for the current/next word |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse per word |
| rd_data | output | 16 | Captured read word |
| mem_addr | output | 16 | External word address |
| mem_cs_n | output | 4 | Active-low bank chip selects |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_dq_o | output | 16 | Data driven to the bus |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_i | input | 16 | Data read from the bus |

## Verification
The configuration port and the request port can act on the same clock edge. The bench therefore raises `req_valid` and a wait-state write in the same cycle. It then measures the strobe width of that word, which must use the old count, and of the following request, which must use the new one. A second overlap happens inside multi-word transfers: a chip-select boundary and an address step fall on one edge. The bench starts runs just below a bank edge and at 0xFFFF, and compares the logged chip select of each strobe and the memory contents against the decode rule.

// File: rtl/sram_part_pkg.sv
package sram_part_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } seq_state_t;

  localparam int unsigned CFG_SEL_WS = 4;
endpackage

// File: rtl/sram_cfg_regs.sv
module sram_cfg_regs #(
  parameter int unsigned BANKS  = 4,
  parameter int unsigned BND_W  = 8,
  parameter int unsigned WS_W   = 3,
  parameter int unsigned CSEL_W = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cfg_we,
  input  logic [CSEL_W-1:0]               cfg_sel,
  input  logic [BND_W-1:0]                cfg_wdata,
  output logic [BANKS-1:0][BND_W-1:0]     bnd,
  output logic [WS_W-1:0]                 ws
);
  localparam int unsigned STEP = (1 << BND_W) / BANKS;

  for (genvar n = 0; n < BANKS; n++) begin : g_bnd
    always_ff @(posedge clk) begin
      if (rst) begin
        bnd[n] <= BND_W'(n * STEP);
      end else if (cfg_we && (cfg_sel == CSEL_W'(n))) begin
        bnd[n] <= cfg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ws <= '0;
    end else if (cfg_we && (cfg_sel == CSEL_W'(sram_part_pkg::CFG_SEL_WS))) begin
      ws <= cfg_wdata[WS_W-1:0];
    end
  end
endmodule

// File: rtl/sram_bank_decode.sv
module sram_bank_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BANKS  = 4,
  parameter int unsigned BND_W  = 8
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic [BANKS-1:0][BND_W-1:0] bnd,
  output logic [BANKS-1:0]            cs_n
);
  localparam int unsigned BIDX_W = (BANKS > 1) ? $clog2(BANKS) : 1;

  logic [BND_W-1:0]  hi;
  logic [BANKS-1:0]  hit;
  logic [BIDX_W-1:0] sel;

  assign hi = addr[ADDR_W-1 -: BND_W];

  for (genvar n = 0; n < BANKS; n++) begin : g_cmp
    assign hit[n] = (hi >= bnd[n]);
  end

  always_comb begin
    sel = '0;
    for (int n = 0; n < BANKS; n++) begin
      if (hit[n]) sel = BIDX_W'(n);
    end
    cs_n = ~(BANKS'(1) << sel);
  end
endmodule

// File: rtl/sram_access_fsm.sv
module sram_access_fsm
  import sram_part_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BANKS  = 4,
  parameter int unsigned WS_W   = 3,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [WS_W-1:0]   ws_cfg,
  output logic [ADDR_W-1:0] next_addr,
  input  logic [BANKS-1:0]  next_cs_n,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BANKS-1:0]  mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  seq_state_t       state;
  logic             wr_q;
  logic [WS_W-1:0]  ws_q;
  logic [WS_W-1:0]  cnt_q;
  logic [LEN_W-1:0] left_q;
  logic             more;

  assign next_addr = (state == ST_IDLE) ? req_addr : mem_addr + ADDR_W'(1);
  assign more      = (left_q > LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      wr_q      <= 1'b0;
      ws_q      <= '0;
      cnt_q     <= '0;
      left_q    <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      rd_data   <= '0;
      mem_addr  <= '0;
      mem_cs_n  <= '1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          done <= 1'b0;
          if (req_valid) begin
            state     <= ST_SETUP;
            busy      <= 1'b1;
            wr_q      <= req_write;
            ws_q      <= ws_cfg;
            left_q    <= (req_len == '0) ? LEN_W'(1) : req_len;
            mem_addr  <= next_addr;
            mem_cs_n  <= next_cs_n;
            mem_dq_o  <= req_wdata;
            mem_dq_oe <= req_write;
          end
        end
        ST_SETUP: begin
          state <= ST_STROBE;
          cnt_q <= ws_q;
          if (wr_q) mem_we_n <= 1'b0;
          else      mem_oe_n <= 1'b0;
        end
        ST_STROBE: begin
          if (cnt_q == '0) begin
            state    <= ST_HOLD;
            mem_we_n <= 1'b1;
            mem_oe_n <= 1'b1;
            done     <= 1'b1;
            if (!wr_q) rd_data <= mem_dq_i;
          end else begin
            cnt_q <= cnt_q - WS_W'(1);
          end
        end
        ST_HOLD: begin
          done <= 1'b0;
          if (more) begin
            state    <= ST_SETUP;
            left_q   <= left_q - LEN_W'(1);
            ws_q     <= ws_cfg;
            mem_addr <= next_addr;
            mem_cs_n <= next_cs_n;
            mem_dq_o <= req_wdata;
          end else begin
            state     <= ST_IDLE;
            busy      <= 1'b0;
            mem_cs_n  <= '1;
            mem_dq_oe <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_part_ctrl.sv
module sram_part_ctrl #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BANKS  = 4,
  parameter int unsigned BND_W  = 8,
  parameter int unsigned WS_W   = 3,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned CSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CSEL_W-1:0] cfg_sel,
  input  logic [BND_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BANKS-1:0]  mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  logic [BANKS-1:0][BND_W-1:0] bnd;
  logic [WS_W-1:0]             ws;
  logic [ADDR_W-1:0]           next_addr;
  logic [BANKS-1:0]            next_cs_n;

  sram_cfg_regs #(
    .BANKS(BANKS), .BND_W(BND_W), .WS_W(WS_W), .CSEL_W(CSEL_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bnd(bnd), .ws(ws)
  );

  sram_bank_decode #(
    .ADDR_W(ADDR_W), .BANKS(BANKS), .BND_W(BND_W)
  ) u_dec (
    .addr(next_addr), .bnd(bnd), .cs_n(next_cs_n)
  );

  sram_access_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANKS(BANKS),
    .WS_W(WS_W), .LEN_W(LEN_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_len(req_len), .req_wdata(req_wdata), .ws_cfg(ws),
    .next_addr(next_addr), .next_cs_n(next_cs_n),
    .busy(busy), .done(done), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );
endmodule

// File: rtl/sram_part_ctrl_chk.sv
module sram_part_ctrl_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BANKS  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [BANKS-1:0]  mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (&mem_cs_n) && mem_we_n && mem_oe_n);

  a_r2_one_select: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($countones(~mem_cs_n) == 1));

  a_r2_strobes_apart: assert property (@(posedge clk) disable iff (rst)
    !(!mem_we_n && !mem_oe_n));

  a_r4_setup_held: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> $stable(mem_addr) && $stable(mem_cs_n) && $stable(mem_dq_o));

  a_r4_release_held: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> $stable(mem_addr) && $stable(mem_cs_n));

  a_r4_drive_during_we: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_dq_oe);

  a_r5_read_addr_held: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> $stable(mem_addr) && $stable(mem_cs_n));

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind sram_part_ctrl sram_part_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANKS(BANKS)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .mem_addr(mem_addr),
  .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_part_ctrl_tb.sv
module sram_part_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [15:0] rd_data, mem_addr, mem_dq_o;
  logic [15:0] mem_dq_i = '0;
  logic [3:0]  mem_cs_n;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  bit [15:0] mem [bit [15:0]];
  int        widths[$];
  logic [3:0] cslog[$];
  logic [15:0] rdq[$];
  int        ndone;
  int        run = 0;
  logic [3:0] run_cs = '1;

  always #5 clk = ~clk;

  sram_part_ctrl dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_len(req_len), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // behavioural memory and strobe monitor, all on the falling edge
  always @(negedge clk) begin
    if (!mem_we_n && mem_dq_oe && !(&mem_cs_n)) mem[mem_addr] = mem_dq_o;
    if (!mem_oe_n) mem_dq_i = mem.exists(mem_addr) ? mem[mem_addr] : 16'h0BAD;
    if (!mem_we_n || !mem_oe_n) begin
      run = run + 1;
      run_cs = mem_cs_n;
    end else if (run > 0) begin
      widths.push_back(run);
      cslog.push_back(run_cs);
      run = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] sel, input logic [7:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_logs();
    widths.delete(); cslog.delete(); rdq.delete(); ndone = 0;
  endtask

  task automatic collect(input bit w, input logic [15:0] base);
    int k = 1;
    forever begin
      if (done) begin
        ndone++;
        if (!w) rdq.push_back(rd_data);
        req_wdata = base + 16'(k);
        k++;
      end
      if (!busy) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic run_req(input logic [15:0] a, input bit w, input logic [15:0] len,
                         input logic [15:0] base);
    @(negedge clk);
    clear_logs();
    req_valid = 1'b1; req_write = w; req_addr = a; req_len = len; req_wdata = base;
    @(negedge clk);
    req_valid = 1'b0;
    collect(w, base);
  endtask

  task automatic t_reset();
    chk("R1 cs idle", 32'(mem_cs_n), 32'hF);
    chk("R1 we idle", 32'(mem_we_n), 1);
    chk("R1 oe idle", 32'(mem_oe_n), 1);
    chk("R1 busy idle", 32'(busy), 0);
    chk("R6 done idle", 32'(done), 0);
  endtask

  task automatic t_single_write();
    run_req(16'h1234, 1'b1, 16'd1, 16'hA5A5);
    chk("R4 mem word", 32'(mem.exists(16'h1234) ? mem[16'h1234] : 16'h0), 32'hA5A5);
    chk("R4 strobe count", widths.size(), 1);
    chk("R4 width ws0", widths[0], 1);
    chk("R3 bank0 select", 32'(cslog[0]), 32'hE);
    chk("R6 done per write", ndone, 1);
  endtask

  task automatic t_read_ws3();
    cfg(3'd4, 8'd3);
    run_req(16'h1234, 1'b0, 16'd1, 16'h0);
    chk("R5 read width ws3", widths[0], 4);
    chk("R5 read data", 32'(rdq[0]), 32'hA5A5);
    chk("R6 done per read", ndone, 1);
    cfg(3'd4, 8'd0);
  endtask

  task automatic t_decode_default();
    logic [15:0] a [5] = '{16'h3FFF, 16'h4000, 16'h8000, 16'hC000, 16'hFFFF};
    logic [3:0]  e [5] = '{4'hE, 4'hD, 4'hB, 4'h7, 4'h7};
    for (int i = 0; i < 5; i++) begin
      run_req(a[i], 1'b0, 16'd1, 16'h0);
      chk("R3 default decode", 32'(cslog[0]), 32'(e[i]));
    end
  endtask

  task automatic t_reprogram();
    cfg(3'd1, 8'h10); cfg(3'd2, 8'h20); cfg(3'd3, 8'h30);
    cfg(3'd5, 8'hFF); cfg(3'd7, 8'h03);
    begin
      logic [15:0] a [4] = '{16'h0F00, 16'h1000, 16'h2F00, 16'h3000};
      logic [3:0]  e [4] = '{4'hE, 4'hD, 4'hB, 4'h7};
      for (int i = 0; i < 4; i++) begin
        run_req(a[i], 1'b0, 16'd1, 16'h0);
        chk("R7 programmed decode", 32'(cslog[0]), 32'(e[i]));
        chk("R7 unused select no ws change", widths[0], 1);
      end
    end
  endtask

  task automatic t_block_write();
    logic [3:0] e [4] = '{4'hD, 4'hD, 4'hB, 4'hB};
    run_req(16'h1FFE, 1'b1, 16'd4, 16'h1000);
    chk("R6 done count block", ndone, 4);
    chk("R8 strobe count block", widths.size(), 4);
    for (int i = 0; i < 4; i++) begin
      logic [15:0] ad = 16'h1FFE + 16'(i);
      chk("R9 block data", 32'(mem.exists(ad) ? mem[ad] : 16'h0), 32'(16'h1000 + 16'(i)));
      chk("R8 per-word decode", 32'(cslog[i]), 32'(e[i]));
    end
  endtask

  task automatic t_block_read();
    run_req(16'h1FFE, 1'b0, 16'd3, 16'h0);
    chk("R8 read count", rdq.size(), 3);
    for (int i = 0; i < 3; i++)
      chk("R8 block read data", 32'(rdq[i]), 32'(16'h1000 + 16'(i)));
  endtask

  task automatic t_ws7_and_wrap();
    cfg(3'd4, 8'hFF);
    run_req(16'h0050, 1'b1, 16'd1, 16'h7777);
    chk("R4 width ws7", widths[0], 8);
    run_req(16'hFFFF, 1'b1, 16'd2, 16'hB0B0);
    chk("R8 wrap word0", 32'(mem[16'hFFFF]), 32'hB0B0);
    chk("R8 wrap word1", 32'(mem.exists(16'h0000) ? mem[16'h0000] : 16'h0), 32'hB0B1);
    chk("R8 wrap cs0", 32'(cslog[0]), 32'h7);
    chk("R8 wrap cs1", 32'(cslog[1]), 32'hE);
  endtask

  task automatic t_len_zero();
    run_req(16'h0200, 1'b1, 16'd0, 16'h1234);
    chk("R8 len zero single", ndone, 1);
    chk("R8 len zero strobes", widths.size(), 1);
    chk("R8 len zero no second word", 32'(mem.exists(16'h0201)), 0);
  endtask

  task automatic t_busy_ignore();
    cfg(3'd4, 8'd2);
    @(negedge clk);
    clear_logs();
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0300; req_len = 16'd1;
    req_wdata = 16'h3333;
    @(negedge clk);
    req_addr = 16'h0301; req_wdata = 16'h4444;
    while (!done) @(negedge clk);
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk("R10 single strobe", widths.size(), 1);
    chk("R10 first word", 32'(mem[16'h0300]), 32'h3333);
    chk("R10 ignored request", 32'(mem.exists(16'h0301)), 0);
  endtask

  task automatic t_cfg_collision();
    cfg(3'd4, 8'd1);
    @(negedge clk);
    clear_logs();
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0400; req_len = 16'd1;
    req_wdata = 16'h5555;
    cfg_we = 1'b1; cfg_sel = 3'd4; cfg_wdata = 8'd5;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    collect(1'b1, 16'h5555);
    chk("R11 same-cycle write keeps old ws", widths[0], 2);
    run_req(16'h0401, 1'b1, 16'd1, 16'h6666);
    chk("R11 later word uses new ws", widths[0], 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single_write();
    t_read_ws3();
    t_decode_default();
    t_reprogram();
    t_block_write();
    t_block_read();
    t_ws7_and_wrap();
    t_len_zero();
    t_busy_ignore();
    t_cfg_collision();
    t_reset();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule